// File: doc/BRIEF.md
# Satellite Control Tone and Message Transmitter

This block drives one output pin with a gated 22 kHz carrier. Software uses it to control outdoor satellite equipment through a byte-wide register interface. A single control byte does several jobs. It can hold a continuous tone, start a short unmodulated burst, start a burst of nine encoded one-bits, or start a coded message of one to six bytes. It also carries a suppress bit that silences the pin in every mode.

The carrier is the top bit of a 19-bit phase accumulator. A programmable 16-bit increment is added to it on every clock. At a 96 MHz clock an increment of 120 gives about 22 kHz. Messages are sent most significant bit first, and each byte is followed by an odd parity bit. The envelope encodes a zero as two thirds of a bit period of tone and a one as one third of tone. After every burst or message there is a silent guard interval, and only then does the block report that it is ready.

The bit period and the guard length are parameters in clock cycles, so a short period can be used in simulation.

Top module: `sec_tone_tx`

## Requirements
- R1: During and directly after reset, `ready` is 1, `env` and `tone_out` are 0, the control register reads 0x00, the status register reads 0x01, and the increment registers read the reset increment (low 0x78, high 0x00 for the default of 120).
- R2: Writes to address 0x10 (control), 0x12/0x13 (increment low/high) and 0x18..0x1D (message bytes 0..5) can be read back on `rd_data` from the same addresses.
- R3: While the block is idle, control bit 0 set gives `env` = 1 from the cycle after the write, and bit 0 clear gives `env` = 0.
- R4: Control bit 7 set forces `env` and `tone_out` to 0 in every mode. The busy/ready timing is unchanged.
- R5: `tone_out` is bit 18 of an accumulator that adds the 16-bit increment on every clock, ANDed with `env`. With an increment of 0x4000 and `env` held high, `tone_out` is high for exactly 32 of any 64 consecutive cycles.
- R6: Writing the control register with bit 3 set sends (bits 6:4)+1 bytes, taken from address 0x18 upward. A length field of 6 or 7 is clamped to six bytes. Each byte is sent MSB first and is followed by a parity bit that makes the number of ones odd. Each bit lasts BIT_CYC cycles. A zero bit has `env` high for the first 2·(BIT_CYC/3) cycles, and a one bit has `env` high for the first BIT_CYC/3 cycles.
- R7: Writing control bits 2:1 = 2'b10 (for example 0x04) holds `env` high for 12.5 bit periods, followed by the guard.
- R8: Writing control bits 2:1 = 2'b11 (for example 0x06) sends nine encoded one-bits, followed by the guard.
- R9: `ready` and status bit 0 go to 0 in the cycle after a start write. They stay 0 through the transmission and through GUARD_CYC further silent cycles, and then return to 1.
- R10: While a transmission runs, the continuous tone setting has no effect on `env`. Once `ready` returns, `env` again follows control bit 0.
- R11: A start command written while `ready` is 0 is ignored, and the transmission in progress keeps its length.
- R12: When control bits 3 and 2 are both set, a message is sent and no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Combinational read data |
| ready | output | 1 | 1 when idle and able to accept a command |
| env | output | 1 | Current modulation envelope after suppression |
| tone_out | output | 1 | Gated carrier pin |

## Verification
A miscounted bit or byte position in the sequencer moves a tone-to-silence edge on `env`. It does so within the bit period in which the error occurs, so comparing `env` against the expected envelope on every cycle catches it at once. A wrong length, a wrong guard count or a start that is wrongly accepted shows up as `ready` rising on the wrong cycle, and the bench checks that cycle exactly. A fault in the accumulator or the gate changes the duty count of `tone_out` within one carrier period.

// File: rtl/sec_pkg.sv
package sec_pkg;
    localparam int ACC_W  = 19;
    localparam int INC_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MSG     = 2'd1,
        ST_BURST_A = 2'd2,
        ST_GUARD   = 2'd3
    } sec_state_e;
endpackage

// File: rtl/sec_phase_acc.sv
module sec_phase_acc
    import sec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    output logic             carrier
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d     = acc_q;
        acc_d.acc = acc_q.acc + ACC_W'(inc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign carrier = acc_q.acc[ACC_W-1];
endmodule

// File: rtl/sec_regs.sv
module sec_regs
    import sec_pkg::*;
#(
    parameter int DEPTH       = 6,
    parameter int CTRL_ADDR   = 8'h10,
    parameter int INC_LO_ADDR = 8'h12,
    parameter int INC_HI_ADDR = 8'h13,
    parameter int MSG_BASE    = 8'h18,
    parameter int INC_RESET   = 120
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [7:0]                    wr_addr,
    input  logic [BYTE_W-1:0]             wr_data,
    output logic [BYTE_W-1:0]             ctrl,
    output logic [INC_W-1:0]              inc,
    output logic [DEPTH-1:0][BYTE_W-1:0]  msg
);
    typedef struct packed {
        logic [BYTE_W-1:0]             ctrl;
        logic [INC_W-1:0]              inc;
        logic [DEPTH-1:0][BYTE_W-1:0]  msg;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == 8'(CTRL_ADDR))   r_d.ctrl      = wr_data;
            if (wr_addr == 8'(INC_LO_ADDR)) r_d.inc[7:0]  = wr_data;
            if (wr_addr == 8'(INC_HI_ADDR)) r_d.inc[15:8] = wr_data;
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_addr == 8'(MSG_BASE + i)) r_d.msg[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.inc  <= INC_W'(INC_RESET);
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl = r_q.ctrl;
    assign inc  = r_q.inc;
    assign msg  = r_q.msg;

    // R2: the control register only changes on a write to its address
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 8'(CTRL_ADDR)) |=> $stable(r_q.ctrl));
endmodule

// File: rtl/sec_seq.sv
module sec_seq
    import sec_pkg::*;
#(
    parameter int BIT_CYC   = 144000,
    parameter int GUARD_CYC = 1440000,
    parameter int DEPTH     = 6,
    localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_msg,
    input  logic              start_burst,
    input  logic              burst_b,
    input  logic [2:0]        len_m1,
    input  logic [BYTE_W-1:0] cur_byte,
    output logic [IDX_W-1:0]  byte_idx,
    output logic              busy,
    output logic              env_mod
);
    localparam int BA_CYC  = (BIT_CYC * 25) / 2;
    localparam int MAX1    = (BIT_CYC > BA_CYC) ? BIT_CYC : BA_CYC;
    localparam int MAXC    = (MAX1 > GUARD_CYC) ? MAX1 : GUARD_CYC;
    localparam int CW      = $clog2(MAXC + 1);
    localparam int THIRD   = BIT_CYC / 3;
    localparam int TWO_3RD = 2 * THIRD;

    typedef struct packed {
        sec_state_e        state;
        logic [CW-1:0]     cyc;
        logic [3:0]        bitn;
        logic [IDX_W-1:0]  byten;
        logic [IDX_W-1:0]  nbytes;
        logic              isb;
    } seq_t;

    seq_t q, d;
    logic [IDX_W-1:0] len_c;
    logic [2:0]       pos;
    logic             cur_bit;

    always_comb begin
        len_c = (int'(len_m1) > DEPTH - 1) ? IDX_W'(DEPTH - 1) : IDX_W'(len_m1);
        d = q;
        case (q.state)
            ST_IDLE: begin
                if (start_msg) begin
                    d.state  = ST_MSG;
                    d.cyc    = '0;
                    d.bitn   = '0;
                    d.byten  = '0;
                    d.nbytes = len_c;
                    d.isb    = 1'b0;
                end else if (start_burst) begin
                    d.cyc    = '0;
                    d.bitn   = '0;
                    d.byten  = '0;
                    d.nbytes = '0;
                    d.isb    = burst_b;
                    d.state  = burst_b ? ST_MSG : ST_BURST_A;
                end
            end
            ST_MSG: begin
                if (q.cyc == CW'(BIT_CYC - 1)) begin
                    d.cyc = '0;
                    if (q.bitn == 4'd8) begin
                        d.bitn = '0;
                        if (q.byten == q.nbytes) d.state = ST_GUARD;
                        else                     d.byten = q.byten + IDX_W'(1);
                    end else begin
                        d.bitn = q.bitn + 4'd1;
                    end
                end else begin
                    d.cyc = q.cyc + CW'(1);
                end
            end
            ST_BURST_A: begin
                if (q.cyc == CW'(BA_CYC - 1)) begin
                    d.state = ST_GUARD;
                    d.cyc   = '0;
                end else begin
                    d.cyc = q.cyc + CW'(1);
                end
            end
            default: begin
                if (q.cyc == CW'(GUARD_CYC - 1)) begin
                    d.state = ST_IDLE;
                    d.cyc   = '0;
                end else begin
                    d.cyc = q.cyc + CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_IDLE, default: '0};
        else        q <= d;
    end

    always_comb begin
        pos     = 3'(4'd7 - q.bitn);
        cur_bit = q.isb ? 1'b1 : ((q.bitn == 4'd8) ? ~^cur_byte : cur_byte[pos]);
        case (q.state)
            ST_MSG:     env_mod = cur_bit ? (q.cyc < CW'(THIRD)) : (q.cyc < CW'(TWO_3RD));
            ST_BURST_A: env_mod = 1'b1;
            default:    env_mod = 1'b0;
        endcase
    end

    assign busy     = (q.state != ST_IDLE);
    assign byte_idx = q.byten;

    a_r6_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.bitn <= 4'd8);
    a_r6_byte_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.byten <= q.nbytes);
    a_r11_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(q.nbytes));
    a_r9_ready_after_guard: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(q.state == ST_GUARD));
    a_r7_burst_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_BURST_A && $past(q.state != ST_BURST_A)) |-> $past(q.state == ST_IDLE));
endmodule

// File: rtl/sec_tone_tx.sv
module sec_tone_tx
    import sec_pkg::*;
#(
    parameter int BIT_CYC     = 144000,
    parameter int GUARD_CYC   = 1440000,
    parameter int DEPTH       = 6,
    parameter int CTRL_ADDR   = 8'h10,
    parameter int STAT_ADDR   = 8'h11,
    parameter int INC_LO_ADDR = 8'h12,
    parameter int INC_HI_ADDR = 8'h13,
    parameter int MSG_BASE    = 8'h18,
    parameter int INC_RESET   = 120
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       ready,
    output logic       env,
    output logic       tone_out
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [BYTE_W-1:0]            ctrl;
    logic [INC_W-1:0]             inc;
    logic [DEPTH-1:0][BYTE_W-1:0] msg;
    logic [IDX_W-1:0]             byte_idx;
    logic                         busy, env_mod, carrier;
    logic                         ctrl_wr, start_msg, start_burst;

    sec_regs #(
        .DEPTH(DEPTH), .CTRL_ADDR(CTRL_ADDR), .INC_LO_ADDR(INC_LO_ADDR),
        .INC_HI_ADDR(INC_HI_ADDR), .MSG_BASE(MSG_BASE), .INC_RESET(INC_RESET)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl), .inc(inc), .msg(msg)
    );

    assign ctrl_wr     = wr_en && (wr_addr == 8'(CTRL_ADDR));
    assign start_msg   = ctrl_wr && wr_data[3];
    assign start_burst = ctrl_wr && wr_data[2];

    sec_seq #(
        .BIT_CYC(BIT_CYC), .GUARD_CYC(GUARD_CYC), .DEPTH(DEPTH)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_msg(start_msg),
        .start_burst(start_burst), .burst_b(wr_data[1]), .len_m1(wr_data[6:4]),
        .cur_byte(msg[byte_idx]), .byte_idx(byte_idx), .busy(busy),
        .env_mod(env_mod)
    );

    sec_phase_acc u_acc (
        .clk(clk), .rst_n(rst_n), .inc(inc), .carrier(carrier)
    );

    assign ready    = ~busy;
    assign env      = ~ctrl[7] & (busy ? env_mod : ctrl[0]);
    assign tone_out = carrier & env;

    always_comb begin
        rd_data = '0;
        if (rd_addr == 8'(CTRL_ADDR))   rd_data = ctrl;
        if (rd_addr == 8'(STAT_ADDR))   rd_data = {7'd0, ready};
        if (rd_addr == 8'(INC_LO_ADDR)) rd_data = inc[7:0];
        if (rd_addr == 8'(INC_HI_ADDR)) rd_data = inc[15:8];
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_addr == 8'(MSG_BASE + i)) rd_data = msg[i];
        end
    end

    a_r10_no_cont_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !env_mod) |-> !env);
    a_r4_suppress_pin: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[7] |-> !tone_out);
    a_r5_rise_needs_env: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tone_out) |-> env);
endmodule

// File: tb/tb_sec_tone_tx.sv
`timescale 1ns/1ps
module tb_sec_tone_tx;
    localparam int BIT   = 30;
    localparam int GRD   = 20;
    localparam int BA    = 375;
    localparam logic [7:0] A_CTRL = 8'h10, A_STAT = 8'h11, A_ILO = 8'h12,
                           A_IHI = 8'h13, A_BASE = 8'h18;

    logic clk = 0, rst_n = 0, wr_en = 0;
    logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0, rd_data;
    logic ready, env, tone_out;
    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [7:0] mbuf [6];

    always #4 clk = ~clk;

    sec_tone_tx #(.BIT_CYC(BIT), .GUARD_CYC(GRD)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ready(ready), .env(env), .tone_out(tone_out));

    // {length, byte0..byte5}
    localparam logic [51:0] VEC [4] = '{
        {4'd1, 48'hE2_00_00_00_00_00},
        {4'd3, 48'hE0_10_38_00_00_00},
        {4'd6, 48'hFF_00_A5_5A_01_80},
        {4'd2, 48'h7E_81_00_00_00_00}};

    task automatic check(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] v);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = v;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] v);
        rd_addr = a; #1; v = rd_data;
    endtask

    task automatic load(logic [47:0] bytes);
        for (int i = 0; i < 6; i++) begin
            mbuf[i] = bytes[47-8*i -: 8];
            wr(A_BASE + 8'(i), mbuf[i]);
        end
    endtask

    // kind 0 message, 1 burst A, 2 burst B
    function automatic int total_len(int kind, int len);
        if (kind == 1) return BA + GRD;
        return ((kind == 2) ? 9 : 9 * len) * BIT + GRD;
    endfunction

    function automatic bit exp_env(int kind, int len, int n);
        int nb, b, ph, j, p;
        bit v;
        logic [7:0] by;
        if (kind == 1) return n < BA;
        nb = (kind == 2) ? 9 : 9 * len;
        if (n >= nb * BIT) return 0;
        b = n / BIT; ph = n % BIT;
        if (kind == 2) v = 1;
        else begin
            j = b / 9; p = b % 9; by = mbuf[j];
            v = (p < 8) ? by[7-p] : ($countones(by) % 2 == 0);
        end
        return v ? (ph < BIT/3) : (ph < 2*(BIT/3));
    endfunction

    task automatic run_seq(logic [7:0] cv, int kind, int len, string req);
        int t, ebad, rbad, first;
        bit ee, er;
        t = total_len(kind, len);
        ebad = 0; rbad = 0; first = -1;
        wr(A_CTRL, cv);
        for (int n = 0; n <= t; n++) begin
            er = (n >= t);
            if (cv[7]) ee = 0;
            else if (n >= t) ee = cv[0];
            else ee = exp_env(kind, len, n);
            if (env !== ee) begin ebad++; if (first < 0) first = n; end
            if (ready !== er) rbad++;
            if (n < t) @(negedge clk);
        end
        check(ebad == 0, req, $sformatf("envelope mismatches (first at %0d)", first), ebad, 0);
        check(rbad == 0, req, "ready timing mismatches (R9)", rbad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int cnt, n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ready === 1 && env === 0 && tone_out === 0, "R1", "outputs in reset", {ready, env, tone_out}, 4);
        rst_n = 1;
        @(negedge clk);
        rd(A_CTRL, v); check(v === 8'h00, "R1", "ctrl reset", v, 0);
        rd(A_STAT, v); check(v === 8'h01, "R1", "status reset", v, 1);
        rd(A_ILO, v);  check(v === 8'h78, "R1", "inc low reset", v, 8'h78);
        rd(A_IHI, v);  check(v === 8'h00, "R1", "inc high reset", v, 0);

        // R2 readback
        load(48'h11_22_33_44_55_66);
        cnt = 0;
        for (int i = 0; i < 6; i++) begin
            rd(A_BASE + 8'(i), v); if (v !== mbuf[i]) cnt++;
        end
        check(cnt == 0, "R2", "message byte readback mismatches", cnt, 0);
        wr(A_ILO, 8'h5A); wr(A_IHI, 8'hC3);
        rd(A_ILO, v); check(v === 8'h5A, "R2", "inc low readback", v, 8'h5A);
        rd(A_IHI, v); check(v === 8'hC3, "R2", "inc high readback", v, 8'hC3);
        wr(A_ILO, 8'h78); wr(A_IHI, 8'h00);

        // R6 table of messages
        for (int k = 0; k < 4; k++) begin
            load(VEC[k][47:0]);
            run_seq({1'b0, 3'(VEC[k][51:48] - 4'd1), 4'b1000}, 0, int'(VEC[k][51:48]), "R6");
        end

        // R7 burst A, R8 burst B
        run_seq(8'h04, 1, 0, "R7");
        run_seq(8'h06, 2, 0, "R8");

        // R6 length clamp (field 7 -> six bytes)
        load(48'hA1_B2_C3_D4_E5_F6);
        run_seq(8'h78, 0, 6, "R6");

        // R12 message wins over burst
        run_seq(8'h0C, 0, 1, "R12");

        // R4 suppressed message keeps timing
        run_seq(8'h88, 0, 1, "R4");

        // R3 continuous tone, R10 forced off and restored
        wr(A_CTRL, 8'h01);
        check(env === 1, "R3", "continuous tone on", env, 1);
        run_seq(8'h07, 2, 0, "R10");
        wr(A_CTRL, 8'h00);
        check(env === 0, "R3", "continuous tone off", env, 0);

        // R5 carrier duty
        wr(A_ILO, 8'h00); wr(A_IHI, 8'h40); wr(A_CTRL, 8'h01);
        repeat (4) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 64; i++) begin cnt += tone_out; @(negedge clk); end
        check(cnt == 32, "R5", "tone_out high count over 64 cycles", cnt, 32);
        wr(A_CTRL, 8'h81);
        cnt = 0;
        for (int i = 0; i < 64; i++) begin cnt += tone_out; @(negedge clk); end
        check(cnt == 0, "R4", "suppressed tone_out high count", cnt, 0);
        wr(A_CTRL, 8'h00);

        // R11 start while busy ignored
        wr(A_CTRL, 8'h04);
        repeat (50) @(negedge clk);
        wr(A_CTRL, 8'h08);
        n = 52;
        rd(A_STAT, v); check(v === 8'h00, "R9", "status while busy", v, 0);
        cnt = 0;
        for (; n <= BA + GRD; n++) begin
            if (ready !== (n >= BA + GRD) || env !== (n < BA)) cnt++;
            if (n < BA + GRD) @(negedge clk);
        end
        check(cnt == 0, "R11", "burst A timing after ignored start", cnt, 0);
        @(negedge clk);
        check(ready === 1, "R11", "no deferred start", ready, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule